// File: doc/BRIEF.md
# Serial Register-State Transfer Engine

This block carries a thread's full architected register image between two cores through ordinary memory traffic when the thread is migrated. A save phase, run on the core the thread is leaving, reads the local register file one entry per step and writes each value to a per-thread slot inside a physical address window set aside for parked thread state. A restore phase, run on the core that takes the thread over, reads that slot back one word at a time and writes each word into the local register file. The same pair of phases, with the roles of the cores swapped, returns the thread to its home core when the kernel event that caused the move has been handled.

The engine is started with a one-cycle request that carries the direction and the thread number. It reports progress with a busy level and a one-cycle done pulse. The image has a fixed size: 277 registers of 64 bits, about 2.2 kB. Thread t owns the slot that begins at SAVE_BASE + t × 277 × 8, and register i sits at byte offset 8 × i inside that slot. Words move in ascending register order, and only one memory access is in flight at any time. When a phase ends, the engine publishes the number of cycles the phase was busy, so that the cost of each migration can be read off.

Top module: `regXferEngine`

## Requirements
- R1: While reset is held and after it is released, busy, done, rfRdEn, rfWrEn and memReqValid are 0, and phaseCycles reads 0.
- R2: A startReq that is seen while busy is 0 is accepted, and busy is 1 in the next cycle. A startReq that is seen while busy is 1, including the cycle in which done is high, has no effect on the running phase or on the one after it.
- R3: A save phase (startDir = 0) reads register indices 0 to 276 in ascending order over the read port. For each index i it issues one write request (memReqWrite = 1) to SAVE_BASE + tid × 2216 + 8 × i that carries the value read.
- R4: A restore phase (startDir = 1) issues read requests (memReqWrite = 0) to the same addresses in ascending order. It writes each returned word into register index i in that order.
- R5: After a request is accepted (memReqValid and memReqReady both 1), no new request is raised until memRspValid has been seen.
- R6: While memReqValid is 1 and memReqReady is 0, the request stays raised and its address, data and direction do not change.
- R7: done is high for exactly one cycle, and busy is 0 in the cycle after it. In a save, done is high in the cycle after the one in which the final write response arrives. In a restore, done is high in the cycle after the final register-file write.
- R8: In the cycle after done, phaseCycles equals the number of cycles busy was 1 during that phase, counting the done cycle. It keeps that value until the next phase completes.
- R9: A save of thread A followed by a save of thread B leaves the slot of thread A unchanged. A later restore of thread A returns thread A's image exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to begin a phase |
| startDir | input | 1 | 0 = save to memory, 1 = restore from memory |
| threadId | input | TID_W | Thread whose slot is used |
| busy | output | 1 | A phase is in progress |
| done | output | 1 | One-cycle pulse at the end of a phase |
| phaseCycles | output | CNT_W | Busy-cycle count of the last completed phase |
| rfRdEn | output | 1 | Register-file read strobe |
| rfRdIdx | output | IDX_W | Register-file read index |
| rfRdData | input | DATA_W | Read data, valid the cycle after rfRdEn |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrIdx | output | IDX_W | Register-file write index |
| rfWrData | output | DATA_W | Register-file write data |
| memReqValid | output | 1 | Memory request raised |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memReqWrite | output | 1 | 1 = write request, 0 = read request |
| memReqAddr | output | ADDR_W | Byte address of the request |
| memReqWdata | output | DATA_W | Write data |
| memRspValid | input | 1 | Response for the outstanding request |
| memRspRdata | input | DATA_W | Read data carried with the response |

## Verification
The memory and register-file models answer at the falling edge. A request is taken up at the rising edge that follows, a read-port value is sampled by the engine one rising edge after the read strobe, and the response arrives after a random delay of one to three cycles with random back-pressure. The bench predicts done for the first falling edge after the final write response (save) or after the final register-file write (restore), and it flags a done seen at any other edge. It checks phaseCycles one falling edge later against its own count of busy cycles. Every request address, every read index and every write index is compared with the next expected ascending slot as it appears. Stray start requests are driven mid-phase and in the done cycle, so that any effect they had would show up in those per-access checks.

// File: rtl/regXferPkg.sv
package regXferPkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_RF_RD,
    XS_RF_CAP,
    XS_MEM_REQ,
    XS_MEM_WAIT,
    XS_RF_WR,
    XS_FINISH
  } xferStateT;

  typedef struct packed {
    logic launch;   // accept a start: clear index, latch thread, seed counter
    logic stepIdx;  // advance to the next register
    logic grabRf;   // capture register-file read data
    logic grabMem;  // capture memory response data
    logic tally;    // count one busy cycle
    logic close;    // publish the cycle count
  } xferStrobesT;

endpackage

// File: rtl/regXferCtrl.sv
module regXferCtrl
  import regXferPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        startDir,
  input  logic        lastIdx,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output xferStrobesT strobes,
  output logic        busy,
  output logic        done,
  output logic        rfRdEn,
  output logic        rfWrEn,
  output logic        memReqValid,
  output logic        memReqWrite
);

  xferStateT state, nextState;
  logic      dirRestore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= XS_IDLE;
      dirRestore <= 1'b0;
    end else begin
      state <= nextState;
      if (strobes.launch) dirRestore <= startDir;
    end
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      XS_IDLE: begin
        if (startReq) begin
          strobes.launch = 1'b1;
          nextState      = startDir ? XS_MEM_REQ : XS_RF_RD;
        end
      end
      XS_RF_RD:  nextState = XS_RF_CAP;
      XS_RF_CAP: begin
        strobes.grabRf = 1'b1;
        nextState      = XS_MEM_REQ;
      end
      XS_MEM_REQ: begin
        if (memReqReady) nextState = XS_MEM_WAIT;
      end
      XS_MEM_WAIT: begin
        if (memRspValid) begin
          if (dirRestore) begin
            strobes.grabMem = 1'b1;
            nextState       = XS_RF_WR;
          end else if (lastIdx) begin
            nextState = XS_FINISH;
          end else begin
            strobes.stepIdx = 1'b1;
            nextState       = XS_RF_RD;
          end
        end
      end
      XS_RF_WR: begin
        if (lastIdx) begin
          nextState = XS_FINISH;
        end else begin
          strobes.stepIdx = 1'b1;
          nextState       = XS_MEM_REQ;
        end
      end
      XS_FINISH: begin
        strobes.close = 1'b1;
        nextState     = XS_IDLE;
      end
      default: nextState = XS_IDLE;
    endcase
    strobes.tally = (state != XS_IDLE) && (state != XS_FINISH);
  end

  assign busy        = (state != XS_IDLE);
  assign done        = (state == XS_FINISH);
  assign rfRdEn      = (state == XS_RF_RD);
  assign rfWrEn      = (state == XS_RF_WR);
  assign memReqValid = (state == XS_MEM_REQ);
  assign memReqWrite = !dirRestore;

endmodule

// File: rtl/regXferPath.sv
module regXferPath
  import regXferPkg::*;
#(
  parameter int              NUM_REGS  = 277,
  parameter int              DATA_W    = 64,
  parameter int              ADDR_W    = 32,
  parameter int              TID_W     = 4,
  parameter int              CNT_W     = 16,
  parameter logic [ADDR_W-1:0] SAVE_BASE = 32'h0010_0000,
  localparam int             IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobesT       strobes,
  input  logic [TID_W-1:0]  threadId,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [DATA_W-1:0] memRspRdata,
  output logic [IDX_W-1:0]  regIdx,
  output logic              lastIdx,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] stageData,
  output logic [CNT_W-1:0]  phaseCycles
);

  localparam int              WORD_BYTES   = DATA_W / 8;
  localparam int              WORD_SHIFT   = $clog2(WORD_BYTES);
  localparam int              REGION_BYTES = NUM_REGS * WORD_BYTES;
  localparam logic [ADDR_W-1:0] REGION_A   = ADDR_W'(REGION_BYTES);
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(NUM_REGS - 1);

  logic [TID_W-1:0]  tidReg;
  logic [CNT_W-1:0]  cycleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regIdx      <= '0;
      tidReg      <= '0;
      stageData   <= '0;
      cycleCnt    <= '0;
      phaseCycles <= '0;
    end else begin
      if (strobes.launch) begin
        regIdx   <= '0;
        tidReg   <= threadId;
        cycleCnt <= CNT_W'(1);
      end else begin
        if (strobes.stepIdx) regIdx <= regIdx + 1'b1;
        if (strobes.tally && (cycleCnt != {CNT_W{1'b1}})) cycleCnt <= cycleCnt + 1'b1;
      end
      if (strobes.grabRf)       stageData <= rfRdData;
      else if (strobes.grabMem) stageData <= memRspRdata;
      if (strobes.close) phaseCycles <= cycleCnt;
    end
  end

  assign lastIdx    = (regIdx == LAST_IDX);
  assign memReqAddr = SAVE_BASE
                    + (ADDR_W'(tidReg) * REGION_A)
                    + (ADDR_W'(regIdx) << WORD_SHIFT);

endmodule

// File: rtl/regXferEngine.sv
module regXferEngine
  import regXferPkg::*;
#(
  parameter int              NUM_REGS  = 277,
  parameter int              DATA_W    = 64,
  parameter int              ADDR_W    = 32,
  parameter int              TID_W     = 4,
  parameter int              CNT_W     = 16,
  parameter logic [ADDR_W-1:0] SAVE_BASE = 32'h0010_0000,
  localparam int             IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              startDir,
  input  logic [TID_W-1:0]  threadId,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  phaseCycles,
  output logic              rfRdEn,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspRdata
);

  xferStrobesT       strobes;
  logic              lastIdx;
  logic [IDX_W-1:0]  regIdx;
  logic [DATA_W-1:0] stageData;

  regXferCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .startDir    (startDir),
    .lastIdx     (lastIdx),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done),
    .rfRdEn      (rfRdEn),
    .rfWrEn      (rfWrEn),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite)
  );

  regXferPath #(
    .NUM_REGS  (NUM_REGS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .TID_W     (TID_W),
    .CNT_W     (CNT_W),
    .SAVE_BASE (SAVE_BASE)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .threadId    (threadId),
    .rfRdData    (rfRdData),
    .memRspRdata (memRspRdata),
    .regIdx      (regIdx),
    .lastIdx     (lastIdx),
    .memReqAddr  (memReqAddr),
    .stageData   (stageData),
    .phaseCycles (phaseCycles)
  );

  assign rfRdIdx     = regIdx;
  assign rfWrIdx     = regIdx;
  assign rfWrData    = stageData;
  assign memReqWdata = stageData;

endmodule

// File: rtl/regXferChecker.sv
module regXferChecker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  phaseCycles,
  input logic              rfRdEn,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWdata,
  input logic              memRspValid
);

  logic inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          inFlight <= 1'b0;
    else if (memReqValid && memReqReady) inFlight <= 1'b1;
    else if (memRspValid)                inFlight <= 1'b0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfRdEn |=> !rfRdEn);

  // R5
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !memReqValid);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWdata) && $stable(memReqWrite)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(phaseCycles));

endmodule

bind regXferEngine regXferChecker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .busy        (busy),
  .done        (done),
  .phaseCycles (phaseCycles),
  .rfRdEn      (rfRdEn),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr),
  .memReqWdata (memReqWdata),
  .memRspValid (memRspValid)
);

// File: tb/sim_regXferEngine.sv
`timescale 1ns/1ps
module sim_regXferEngine;

  localparam int          NR     = 277;
  localparam int          TIDS   = 16;
  localparam int          IW     = 9;
  localparam logic [31:0] BASE   = 32'h0010_0000;
  localparam int          XFER_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startReq, startDir;
  logic [3:0]  threadId;
  logic        busy, done;
  logic [15:0] phaseCycles;
  logic        rfRdEn, rfWrEn;
  logic [IW-1:0] rfRdIdx, rfWrIdx;
  logic [63:0] rfRdData, rfWrData;
  logic        memReqValid, memReqReady, memReqWrite;
  logic [31:0] memReqAddr;
  logic [63:0] memReqWdata;
  logic        memRspValid;
  logic [63:0] memRspRdata;

  always #5 clk = ~clk;

  regXferEngine u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startDir(startDir),
    .threadId(threadId), .busy(busy), .done(done), .phaseCycles(phaseCycles),
    .rfRdEn(rfRdEn), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspRdata(memRspRdata)
  );

  int checks = 0;
  int errors = 0;

  logic [63:0] rfSrc [NR];
  logic [63:0] rfDst [NR];
  logic [63:0] imgA  [NR];
  logic [63:0] mem   [TIDS*NR];

  int  curTid, expIdx, rdIdxExp, wrIdxExp, busyCnt, rspDelay;
  bit  curRestore, rspPending, expectDone, doneSeen, wrongDone;
  logic [63:0] rspData;

  function automatic logic [31:0] slotAddr(int tid, int idx);
    return BASE + 32'(tid * NR * 8) + 32'(idx * 8);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Models of memory and register files, evaluated at each falling edge.
  task automatic modelStep();
    if (busy) busyCnt++;
    if (done) begin
      if (expectDone) doneSeen = 1'b1;
      else wrongDone = 1'b1;
    end else if (expectDone) begin
      chk(1'b0, "R7", "done missing at predicted cycle", 0, 1);
    end
    expectDone = 1'b0;

    memRspValid = 1'b0;
    if (rspPending) begin
      rspDelay--;
      if (rspDelay == 0) begin
        memRspValid = 1'b1;
        memRspRdata = rspData;
        rspPending  = 1'b0;
        if (!curRestore && expIdx == NR) expectDone = 1'b1;
      end
    end

    memReqReady = 1'b0;
    if (memReqValid) begin
      if (rspPending || memRspValid)
        chk(1'b0, "R5", "request raised while one outstanding", 1, 0);
      if (($urandom % 4) != 0) begin
        memReqReady = 1'b1;
        if (expIdx >= NR) begin
          chk(1'b0, "R3", "request beyond last register", expIdx, NR - 1);
        end else begin
          chk(memReqAddr == slotAddr(curTid, expIdx), curRestore ? "R4" : "R3",
              "request address", memReqAddr, slotAddr(curTid, expIdx));
          chk(memReqWrite == !curRestore, curRestore ? "R4" : "R3",
              "request direction", memReqWrite, !curRestore);
          if (memReqWrite) begin
            chk(memReqWdata == rfSrc[expIdx], "R3", "write data",
                memReqWdata, rfSrc[expIdx]);
            mem[curTid*NR + expIdx] = memReqWdata;
          end else begin
            rspData = mem[curTid*NR + expIdx];
          end
        end
        expIdx++;
        rspPending = 1'b1;
        rspDelay   = 1 + int'($urandom % 3);
      end
    end

    if (rfRdEn) begin
      chk(int'(rfRdIdx) == rdIdxExp, "R3", "read index order", rfRdIdx, rdIdxExp);
      if (int'(rfRdIdx) < NR) rfRdData = rfSrc[rfRdIdx];
      rdIdxExp++;
    end

    if (rfWrEn) begin
      chk(int'(rfWrIdx) == wrIdxExp, "R4", "write index order", rfWrIdx, wrIdxExp);
      if (int'(rfWrIdx) < NR) rfDst[rfWrIdx] = rfWrData;
      wrIdxExp++;
      if (wrIdxExp == NR) expectDone = 1'b1;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    modelStep();
  endtask

  // strayAt: cycle offset at which a stray start is driven mid-phase (0 = none)
  task automatic runPhase(int tid, bit restore, int strayAt, bit strayInDone);
    curTid = tid; curRestore = restore;
    expIdx = 0; rdIdxExp = 0; wrIdxExp = 0; busyCnt = 0;
    doneSeen = 1'b0; wrongDone = 1'b0;
    if (restore) for (int i = 0; i < NR; i++) rfDst[i] = '0;
    startReq = 1'b1; startDir = restore; threadId = 4'(tid);
    tick();
    startReq = 1'b0; threadId = 4'(tid ^ 5); startDir = !restore;
    chk(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
    for (int c = 1; c < XFER_LIMIT && !doneSeen; c++) begin
      if (strayAt != 0 && c == strayAt) startReq = 1'b1;
      tick();
      startReq = 1'b0;
    end
    chk(doneSeen, "R7", "watchdog: phase did not complete", doneSeen, 1);
    chk(!wrongDone, "R7", "done at an unpredicted cycle", wrongDone, 0);
    if (strayInDone) startReq = 1'b1;
    tick();
    startReq = 1'b0;
    chk(done == 1'b0, "R7", "done longer than one cycle", done, 0);
    chk(busy == 1'b0, "R2", "idle after done (start in done cycle ignored)", busy, 0);
    chk(int'(phaseCycles) == busyCnt, "R8", "phase cycle count", phaseCycles, busyCnt);
    chk(expIdx == NR, "R3", "number of memory requests", expIdx, NR);
    tick();
    chk(busy == 1'b0 && !memReqValid && !rfRdEn, "R2", "stays idle", busy, 0);
    chk(int'(phaseCycles) == busyCnt - 1 + 1, "R8", "count held while idle", phaseCycles, busyCnt);
  endtask

  function automatic int cmpDst(const ref logic [63:0] img [NR]);
    int bad = 0;
    for (int i = 0; i < NR; i++) if (rfDst[i] !== img[i]) bad++;
    return bad;
  endfunction

  initial begin
    int bad;
    void'($urandom(32'd20240611));
    rstN = 1'b0; startReq = 1'b0; startDir = 1'b0; threadId = '0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspRdata = '0; rfRdData = '0;
    rspPending = 1'b0; expectDone = 1'b0; rspDelay = 0; rspData = '0;
    for (int i = 0; i < TIDS*NR; i++) mem[i] = 64'hDEAD_0000_0000_0000 | 64'(i);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rfRdEn && !rfWrEn && !memReqValid, "R1",
        "outputs under reset", {busy, done, rfRdEn, rfWrEn, memReqValid}, 0);
    rstN = 1'b1;
    tick();
    chk(phaseCycles == '0 && !busy, "R1", "count and busy after reset", phaseCycles, 0);

    // Image A: random plus directed extremes at the ends.
    for (int i = 0; i < NR; i++) rfSrc[i] = {$urandom, $urandom};
    rfSrc[0] = '1; rfSrc[NR-1] = '0;
    for (int i = 0; i < NR; i++) imgA[i] = rfSrc[i];

    runPhase(3, 1'b0, 0, 1'b0);
    bad = 0;
    for (int i = 0; i < NR; i++) if (mem[3*NR + i] !== imgA[i]) bad++;
    chk(bad == 0, "R3", "slot of thread 3 holds image", bad, 0);

    runPhase(3, 1'b1, 40, 1'b0);
    bad = cmpDst(imgA);
    chk(bad == 0, "R4", "restored image of thread 3", bad, 0);

    // Image B into the highest thread slot, with a stray start mid-phase.
    for (int i = 0; i < NR; i++) rfSrc[i] = {$urandom, $urandom};
    runPhase(TIDS-1, 1'b0, 123, 1'b0);
    bad = 0;
    for (int i = 0; i < NR; i++) if (mem[3*NR + i] !== imgA[i]) bad++;
    chk(bad == 0, "R9", "thread 3 slot untouched by another save", bad, 0);

    runPhase(TIDS-1, 1'b1, 0, 1'b1);
    bad = cmpDst(rfSrc);
    chk(bad == 0, "R4", "restored image of thread 15", bad, 0);

    runPhase(3, 1'b1, 0, 1'b0);
    bad = cmpDst(imgA);
    chk(bad == 0, "R9", "thread 3 image returns after other traffic", bad, 0);

    // Thread 0 save with a start raised in the done cycle.
    for (int i = 0; i < NR; i++) rfSrc[i] = 64'(i) * 64'h0101_0101_0101_0101;
    runPhase(0, 1'b0, 7, 1'b1);
    bad = 0;
    for (int i = 0; i < NR; i++) if (mem[i] !== rfSrc[i]) bad++;
    chk(bad == 0, "R3", "slot of thread 0 holds image", bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule